// File: doc/BRIEF.md
# Paired Micro-Operation Queue with Read-Side Splitting

This block is a queue that sits between instruction decode and the execution back end. Each slot holds one entry. An entry is either a single W-bit micro-operation or a paired entry. A paired entry carries two similar W-bit micro-operations, one for each half of a 2W-bit vector operation. Up to LANES entries can be written per cycle. The read port issues one W-bit micro-operation per cycle. A paired entry is expanded at the read port into its two halves, low half first, and its slot is released only when the high half leaves.

The block reports its occupancy and the number of free slots. It also drives a front-end gating request with hysteresis: the request rises once occupancy exceeds an upper mark and falls once occupancy drops under a lower mark. A flush input discards every entry in one cycle, including a pair whose low half has already left.

Top module: `muq_top`

## Requirements
- R1: After reset the queue is empty: `occupancy` is 0, `free_slots` equals DEPTH, `rd_valid` is 0 and `fe_gate` is 0.
- R2: All valid write lanes that fit are stored in one cycle, and they are read out in lane order, lane 0 first.
- R3: `free_slots` equals DEPTH minus `occupancy`. A valid lane is accepted (`wr_accept` bit 1) only if the number of valid lanes below it is less than `free_slots`. Every other lane is refused and not stored.
- R4: A plain entry (`wr_lam` bit 0) issues once, with `rd_data` equal to its low field, `rd_half` 0 and `rd_last` 1.
- R5: A paired entry (`wr_lam` bit 1) issues its low field with `rd_half` 0 and `rd_last` 0. The next accepted read issues its high field with `rd_half` 1 and `rd_last` 1. The entry keeps its slot until that second read.
- R6: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data`, `rd_half` and `rd_last` hold their values.
- R7: A write and a read that retires an entry in the same cycle leave `occupancy` changed by accepted writes minus one.
- R8: `fe_gate` is 1 whenever `occupancy` is above `hi_mark`, 0 whenever it is below `lo_mark`, and otherwise keeps its previous value. It changes on the same edge as `occupancy`.
- R9: `flush` empties the queue on the next edge. It drops writes made in that cycle, clears a partly issued pair, and clears `fe_gate`.
- R10: `occupancy` counts stored entries, one per entry whether plain or paired, and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| wr_valid | input | LANES | Per-lane write request |
| wr_lam | input | LANES | Per-lane paired flag |
| wr_lo | input | LANES*W | Per-lane low field (the whole op for plain entries) |
| wr_hi | input | LANES*W | Per-lane high field |
| wr_accept | output | LANES | Lane stored this cycle |
| free_slots | output | CW | Free slot count |
| rd_ready | input | 1 | Consumer takes the issued micro-operation |
| rd_valid | output | 1 | A micro-operation is offered |
| rd_data | output | W | Issued W-bit micro-operation |
| rd_half | output | 1 | 0 = low half or plain, 1 = high half |
| rd_last | output | 1 | This issue releases the slot |
| hi_mark | input | CW | Upper gating mark |
| lo_mark | input | CW | Lower gating mark |
| fe_gate | output | 1 | Front-end clock-gate request |
| occupancy | output | CW | Stored entry count |

## Verification
The bench builds the queue with DEPTH 8, LANES 3, W 16 and marks 5 and 2. With these values a few three-lane bursts fill the queue. This brings within reach:
- a partly refused burst, and a burst with a gap in its lanes;
- the full state;
- both gating transitions, and the band where `fe_gate` holds its value.

A flush placed between the two halves of a pair shows that the split state is discarded.

// File: rtl/muq_pkg.sv
package muq_pkg;
  // Next value of a hysteresis request from occupancy and two marks.
  function automatic logic gate_next(input logic cur, input int unsigned occ,
                                     input int unsigned hi, input int unsigned lo);
    if (occ > hi) return 1'b1;
    if (occ < lo) return 1'b0;
    return cur;
  endfunction

  // A lane may take a slot when fewer accepted lanes precede it than slots are free.
  function automatic logic lane_fits(input int unsigned rank, input int unsigned free);
    return rank < free;
  endfunction
endpackage

// File: rtl/muq_wr_sel.sv
module muq_wr_sel #(
  parameter int LANES = 3,
  parameter int CW    = 4
) (
  input  logic [LANES-1:0]    wr_valid,
  input  logic [CW-1:0]       free,
  output logic [LANES-1:0]    accept,
  output logic [LANES*CW-1:0] offs,
  output logic [CW-1:0]       n_acc
);
  import muq_pkg::*;
  logic [CW-1:0] rank;
  always_comb begin
    rank = '0;
    for (int i = 0; i < LANES; i++) begin
      offs[i*CW +: CW] = rank;
      accept[i] = wr_valid[i] && lane_fits(int'(rank), int'(free));
      if (accept[i]) rank = rank + 1'b1;
    end
    n_acc = rank;
  end
endmodule

// File: rtl/muq_split.sv
module muq_split (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic nonempty,
  input  logic head_lam,
  input  logic rd_ready,
  output logic rd_valid,
  output logic rd_half,
  output logic rd_last,
  output logic fire,
  output logic pop
);
  logic hi_pend;
  assign rd_valid = nonempty;
  assign rd_half  = hi_pend;
  assign rd_last  = nonempty && (!head_lam || hi_pend);
  assign fire     = rd_valid && rd_ready;
  assign pop      = fire && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n || flush)        hi_pend <= 1'b0;
    else if (pop)               hi_pend <= 1'b0;
    else if (fire && head_lam)  hi_pend <= 1'b1;
  end
endmodule

// File: rtl/muq_gate.sv
module muq_gate #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] occ_next,
  input  logic [CW-1:0] hi_mark,
  input  logic [CW-1:0] lo_mark,
  output logic          fe_gate
);
  import muq_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n || flush) fe_gate <= 1'b0;
    else fe_gate <= gate_next(fe_gate, int'(occ_next), int'(hi_mark), int'(lo_mark));
  end
endmodule

// File: rtl/muq_top.sv
module muq_top #(
  parameter int DEPTH = 8,
  parameter int LANES = 3,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [LANES-1:0] wr_valid,
  input  logic [LANES-1:0] wr_lam,
  input  logic [LANES*W-1:0] wr_lo,
  input  logic [LANES*W-1:0] wr_hi,
  output logic [LANES-1:0] wr_accept,
  output logic [CW-1:0]    free_slots,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  output logic             rd_half,
  output logic             rd_last,
  input  logic [CW-1:0]    hi_mark,
  input  logic [CW-1:0]    lo_mark,
  output logic             fe_gate,
  output logic [CW-1:0]    occupancy
);
  logic [W-1:0]       lo_q [DEPTH];
  logic [W-1:0]       hi_q [DEPTH];
  logic [DEPTH-1:0]   lam_q;
  logic [AW-1:0]      wptr, rptr;
  logic [CW-1:0]      count, count_nx, n_acc;
  logic [LANES*CW-1:0] offs;
  logic               fire_w, pop_w;

  assign free_slots = CW'(DEPTH) - count;
  assign occupancy  = count;

  muq_wr_sel #(.LANES(LANES), .CW(CW)) u_sel (
    .wr_valid(wr_valid), .free(free_slots), .accept(wr_accept),
    .offs(offs), .n_acc(n_acc));

  muq_split u_split (
    .clk(clk), .rst_n(rst_n), .flush(flush), .nonempty(count != '0),
    .head_lam(lam_q[rptr]), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_half(rd_half), .rd_last(rd_last), .fire(fire_w), .pop(pop_w));

  assign rd_data = rd_half ? hi_q[rptr] : lo_q[rptr];

  always_comb begin
    if (flush) count_nx = '0;
    else       count_nx = count + n_acc - CW'(pop_w);
  end

  muq_gate #(.CW(CW)) u_gate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .occ_next(count_nx),
    .hi_mark(hi_mark), .lo_mark(lo_mark), .fe_gate(fe_gate));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      count <= '0;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      count <= count_nx;
      wptr  <= wptr + AW'(n_acc);
      if (pop_w) rptr <= rptr + 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [AW-1:0] slot;
      assign slot = wptr + AW'(offs[g*CW +: CW]);
      always_ff @(posedge clk) begin
        if (wr_accept[g] && !flush) begin
          lo_q[slot]  <= wr_lo[g*W +: W];
          hi_q[slot]  <= wr_hi[g*W +: W];
          lam_q[slot] <= wr_lam[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/muq_chk.sv
module muq_chk #(
  parameter int DEPTH = 8,
  parameter int LANES = 3,
  parameter int W     = 64,
  parameter int CW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic [LANES-1:0] wr_valid,
  input logic [LANES-1:0] wr_accept,
  input logic [CW-1:0]    free_slots,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic [W-1:0]     rd_data,
  input logic             rd_half,
  input logic             rd_last,
  input logic [CW-1:0]    hi_mark,
  input logic [CW-1:0]    lo_mark,
  input logic             fe_gate,
  input logic [CW-1:0]    occupancy,
  input logic             fire,
  input logic             pop
);
  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(DEPTH));
  // R3
  accept_within_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_accept) <= int'(free_slots));
  // R3
  refuse_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_valid & ~wr_accept) != '0) |-> ($countones(wr_accept) == int'(free_slots)));
  // R5
  hi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_last && !flush) |=> (rd_valid && rd_half));
  // R5
  hi_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_half |-> rd_last);
  // R5
  hold_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rd_last && !flush && wr_accept == '0) |=> occupancy == $past(occupancy));
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occupancy == '0 && !fe_gate && !rd_half));
  // R8
  gate_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy > hi_mark) |-> fe_gate);
  // R8
  gate_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy < lo_mark) |-> !fe_gate);
  // R1
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == '0) |-> !rd_valid);
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=>
      (rd_valid && $stable(rd_data) && $stable(rd_half) && $stable(rd_last)));
  // R4
  pop_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (fire && rd_last));
endmodule

bind muq_top muq_chk #(.DEPTH(DEPTH), .LANES(LANES), .W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .wr_valid(wr_valid),
  .wr_accept(wr_accept), .free_slots(free_slots), .rd_ready(rd_ready),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_half(rd_half), .rd_last(rd_last),
  .hi_mark(hi_mark), .lo_mark(lo_mark), .fe_gate(fe_gate),
  .occupancy(occupancy), .fire(fire_w), .pop(pop_w));

// File: tb/tb_muq_top.sv
module tb_muq_top;
  localparam int D = 8, L = 3, W = 16, CW = 4, HI = 5, LO = 2;

  logic clk = 0, rst_n = 0, flush = 0, rd_ready = 0;
  logic [L-1:0] wr_valid = '0, wr_lam = '0;
  logic [L*W-1:0] wr_lo = '0, wr_hi = '0;
  logic [L-1:0] wr_accept;
  logic [CW-1:0] free_slots, occupancy;
  logic [CW-1:0] hi_mark = CW'(HI), lo_mark = CW'(LO);
  logic rd_valid, rd_half, rd_last, fe_gate;
  logic [W-1:0] rd_data;

  always #2.5 clk = ~clk;

  muq_top #(.DEPTH(D), .LANES(L), .W(W)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit mlam[$];
  logic [W-1:0] mlo[$], mhi[$];
  bit ehalf = 0, eg = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic upd_gate();
    if (mlo.size() > HI) eg = 1;
    else if (mlo.size() < LO) eg = 0;
  endtask

  task automatic chk_state(input string req);
    check(req, "occupancy", occupancy, mlo.size());
    check("R8", "fe_gate", fe_gate, eg);
  endtask

  // Write a burst; expected acceptance computed from the free-slot rule.
  task automatic wr(input logic [L-1:0] v, input logic [L-1:0] lm,
                    input logic [W-1:0] base, input string req);
    int fr = D - mlo.size();
    int r = 0;
    logic [L-1:0] ea = '0;
    for (int i = 0; i < L; i++)
      if (v[i] && r < fr) begin ea[i] = 1; r++; end
    wr_valid = v; wr_lam = lm; rd_ready = 0;
    for (int i = 0; i < L; i++) begin
      wr_lo[i*W +: W] = base + W'(i);
      wr_hi[i*W +: W] = base + W'(i) + 16'h0100;
    end
    #1;
    check("R3", "free_slots", free_slots, fr);
    check(req, "wr_accept", wr_accept, ea);
    step();
    wr_valid = '0;
    for (int i = 0; i < L; i++)
      if (ea[i]) begin
        mlam.push_back(lm[i]);
        mlo.push_back(base + W'(i));
        mhi.push_back(base + W'(i) + 16'h0100);
      end
    upd_gate();
  endtask

  // Take one micro-operation and compare it with the model head.
  task automatic pop(input string req);
    bit last = !mlam[0] || ehalf;
    rd_ready = 1; wr_valid = '0; #1;
    check(req, "rd_valid", rd_valid, 1);
    check(req, "rd_data", rd_data, ehalf ? mhi[0] : mlo[0]);
    check(req, "rd_half", rd_half, ehalf);
    check(req, "rd_last", rd_last, last);
    step();
    rd_ready = 0;
    if (last) begin
      void'(mlam.pop_front()); void'(mlo.pop_front()); void'(mhi.pop_front());
      ehalf = 0;
    end else ehalf = 1;
    upd_gate();
  endtask

  task automatic t_reset();
    #1;
    check("R1", "occupancy", occupancy, 0);
    check("R1", "free_slots", free_slots, D);
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "fe_gate", fe_gate, 0);
  endtask

  task automatic t_plain();
    wr(3'b111, 3'b000, 16'h1000, "R2");
    chk_state("R10");
    for (int i = 0; i < 3; i++) pop("R4");
    chk_state("R10");
  endtask

  task automatic t_lam();
    wr(3'b111, 3'b101, 16'h2000, "R2");
    pop("R5");
    check("R5", "slot held after low half", occupancy, 3);
    for (int i = 0; i < 4; i++) pop("R5");
    chk_state("R10");
  endtask

  task automatic t_stall();
    wr(3'b001, 3'b001, 16'h3000, "R2");
    pop("R5");
    for (int i = 0; i < 2; i++) begin
      #1;
      check("R6", "rd_half held", rd_half, 1);
      check("R6", "rd_data held", rd_data, 16'h3100);
      check("R6", "rd_last held", rd_last, 1);
      step();
    end
    pop("R5");
  endtask

  task automatic t_fill_gate();
    wr(3'b111, 3'b000, 16'h4000, "R2"); chk_state("R8");
    wr(3'b111, 3'b000, 16'h5000, "R2"); chk_state("R8");
    wr(3'b111, 3'b000, 16'h6000, "R3"); chk_state("R10");
    wr(3'b111, 3'b000, 16'h6100, "R3"); chk_state("R10");
    for (int i = 0; i < D; i++) begin
      pop("R2");
      chk_state("R8");
    end
  endtask

  task automatic t_flush();
    wr(3'b111, 3'b000, 16'h7000, "R2");
    wr(3'b111, 3'b000, 16'h7100, "R2");
    wr(3'b001, 3'b000, 16'h7200, "R2");
    wr(3'b101, 3'b000, 16'h7300, "R3");
    chk_state("R10");
    flush = 1; wr_valid = 3'b001; step(); flush = 0; wr_valid = '0;
    mlam.delete(); mlo.delete(); mhi.delete(); ehalf = 0; eg = 0;
    #1;
    chk_state("R9");
    check("R9", "rd_valid", rd_valid, 0);
    check("R9", "free_slots", free_slots, D);
    wr(3'b011, 3'b001, 16'h8000, "R2");
    pop("R5");
    flush = 1; step(); flush = 0;
    mlam.delete(); mlo.delete(); mhi.delete(); ehalf = 0; eg = 0;
    #1;
    check("R9", "split cleared", rd_half, 0);
    chk_state("R9");
    wr(3'b001, 3'b001, 16'h9000, "R9");
    pop("R9");
    pop("R9");
  endtask

  task automatic t_simul();
    wr(3'b011, 3'b000, 16'hA000, "R2");
    wr_valid = 3'b001; wr_lam = '0; wr_lo[W-1:0] = 16'hB000; wr_hi[W-1:0] = 16'hB100;
    rd_ready = 1; #1;
    check("R7", "rd_data", rd_data, mlo[0]);
    check("R7", "wr_accept", wr_accept, 3'b001);
    step();
    rd_ready = 0; wr_valid = '0;
    void'(mlam.pop_front()); void'(mlo.pop_front()); void'(mhi.pop_front());
    mlam.push_back(0); mlo.push_back(16'hB000); mhi.push_back(16'hB100);
    upd_gate();
    check("R7", "occupancy", occupancy, 2);
    pop("R7"); pop("R7");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_plain();
    t_lam();
    t_stall();
    t_fill_gate();
    t_flush();
    t_simul();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule